// File: doc/BRIEF.md
# Link Capability Word Serializer

This block sends a 32-bit link-negotiation capability word as a serial bit stream, one bit per bit-time. Its inputs are the individual fields: a spread-spectrum transmit type flag, a 4-bit requested link rate, and a "not supported" flag and a spread-spectrum flag for each of three speed generations. From these it builds the frame. The start marker is always one and every reserved position is zero. The last bit is an even-parity bit.

A load request presented while the block is idle latches the complete frame. After that, each pulse of the bit-time strobe puts the next bit on the registered serial output. The frame goes out byte 0 first through byte 3, and within each byte from bit 7 down to bit 0, so every multi-bit field leaves big end first. A one-cycle done pulse marks the edge that sends the final bit.

Top module: `capword_serializer`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `ser_out` are all 0.
- R2: The first bit sent after a load (frame byte 0 bit 7) is always 1.
- R3: Bit 6 of byte 0 carries `ss_type`, the second bit on the wire. Bits 3..0 of byte 0 carry `link_rate`, sent as wire bits 5 to 8 starting with `link_rate[3]`.
- R4: Bits 7..2 of byte 1 carry, in that order, `gen_nosup[0]`, `gen_ssc[0]`, `gen_nosup[1]`, `gen_ssc[1]`, `gen_nosup[2]`, `gen_ssc[2]`. Index 0 is generation 1.
- R5: Byte 0 bits 5..4, byte 1 bits 1..0, all of byte 2 and byte 3 bits 7..1 are sent as 0.
- R6: The final bit (byte 3 bit 0) makes the number of ones across all 32 sent bits even.
- R7: A `load_req` sampled while `busy` is 0 latches the fields and sets `busy` at that edge. Field inputs that change afterwards do not alter the frame in flight.
- R8: A `load_req` sampled while `busy` is 1 is ignored, including on the edge that sends the last bit. The frame in flight continues unchanged and no new frame starts.
- R9: While busy, each edge with `bit_en` high moves the next frame bit onto `ser_out`. Edges without `bit_en` leave `ser_out` unchanged.
- R10: The edge carrying the 32nd strobe raises `done` for exactly one cycle and clears `busy` at the same edge.
- R11: An edge with `bit_en` high while idle drives `ser_out` to 0. A load accepted on the same edge sends its first bit only on the next strobe.
- R12: Asserting `rst` in the middle of a frame abandons it. `busy`, `done` and `ser_out` go to 0 and a fresh load works afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Request to latch and send a new frame |
| ss_type | input | 1 | Spread-spectrum transmit type flag |
| link_rate | input | 4 | Requested logical link rate |
| gen_nosup | input | 3 | Per-generation not-supported flags, index 0 = generation 1 |
| gen_ssc | input | 3 | Per-generation spread-spectrum flags, index 0 = generation 1 |
| bit_en | input | 1 | Bit-time strobe |
| ser_out | output | 1 | Registered serial data |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle pulse on the edge of the final bit |

## Verification
Two collisions matter. The first is a load request on the same edge as the final-bit strobe. The bench raises `load_req` together with the 32nd `bit_en` and expects `done` high, `busy` low and, one cycle later, still no new frame, since the request was seen while busy. The second is a load request together with a strobe while idle. The bench expects that edge to drive `ser_out` to 0, raise `busy`, and hold the start bit back until the next strobe. Random gaps between strobes, with conflicting load requests in the gaps, test that the latched frame and the held output stay put.

// File: rtl/capword_pkg.sv
package capword_pkg;
  localparam int FRAME_BITS = 32;
  localparam int RATE_W     = 4;
  localparam int NUM_GEN    = 3;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  // bit index in the frame vector; index FRAME_BITS-1 goes on the wire first
  localparam int START_POS  = FRAME_BITS - 1;   // byte 0 bit 7
  localparam int SST_POS    = FRAME_BITS - 2;   // byte 0 bit 6
  localparam int RATE_MSB   = FRAME_BITS - 5;   // byte 0 bit 3
  localparam int GEN_TOP    = FRAME_BITS - 9;   // byte 1 bit 7
  localparam int PAR_POS    = 0;                // byte 3 bit 0

  typedef logic [FRAME_BITS-1:0] frame_t;
endpackage

// File: rtl/capword_pack.sv
module capword_pack
  import capword_pkg::*;
#(
  parameter int P_RATE_W  = RATE_W,
  parameter int P_NUM_GEN = NUM_GEN
) (
  input  logic                 ss_type,
  input  logic [P_RATE_W-1:0]  link_rate,
  input  logic [P_NUM_GEN-1:0] gen_nosup,
  input  logic [P_NUM_GEN-1:0] gen_ssc,
  output frame_t               frame
);
  frame_t body;

  always_comb begin
    body                              = '0;
    body[START_POS]                   = 1'b1;
    body[SST_POS]                     = ss_type;
    body[RATE_MSB -: P_RATE_W]        = link_rate;
    for (int g = 0; g < P_NUM_GEN; g++) begin
      body[GEN_TOP - 2*g]     = gen_nosup[g];
      body[GEN_TOP - 2*g - 1] = gen_ssc[g];
    end
  end

  // parity slot is still zero in body, so the reduction covers the other bits
  always_comb begin
    frame          = body;
    frame[PAR_POS] = ^body;
  end
endmodule

// File: rtl/capword_shifter.sv
module capword_shifter
  import capword_pkg::*;
#(
  parameter int P_BITS = FRAME_BITS,
  localparam int P_CW  = $clog2(P_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_req,
  input  logic [P_BITS-1:0] frame_in,
  input  logic              bit_en,
  output logic              ser_out,
  output logic              busy,
  output logic              done
);
  logic [P_BITS-1:0] sh_q;
  logic [P_CW-1:0]   cnt_q;
  logic              busy_q, done_q, ser_q;
  logic              last_bit;

  assign last_bit = (cnt_q == P_CW'(P_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ser_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (bit_en) ser_q <= 1'b0;
        if (load_req) begin
          sh_q   <= frame_in;
          cnt_q  <= '0;
          busy_q <= 1'b1;
        end
      end else if (bit_en) begin
        ser_q <= sh_q[P_BITS-1];
        sh_q  <= {sh_q[P_BITS-2:0], 1'b0};
        cnt_q <= cnt_q + 1'b1;
        if (last_bit) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign ser_out = ser_q;
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/capword_serializer.sv
module capword_serializer
  import capword_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load_req,
  input  logic               ss_type,
  input  logic [RATE_W-1:0]  link_rate,
  input  logic [NUM_GEN-1:0] gen_nosup,
  input  logic [NUM_GEN-1:0] gen_ssc,
  input  logic               bit_en,
  output logic               ser_out,
  output logic               busy,
  output logic               done
);
  frame_t frame_w;

  capword_pack #(.P_RATE_W(RATE_W), .P_NUM_GEN(NUM_GEN)) u_pack (
    .ss_type   (ss_type),
    .link_rate (link_rate),
    .gen_nosup (gen_nosup),
    .gen_ssc   (gen_ssc),
    .frame     (frame_w)
  );

  capword_shifter #(.P_BITS(FRAME_BITS)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load_req (load_req),
    .frame_in (frame_w),
    .bit_en   (bit_en),
    .ser_out  (ser_out),
    .busy     (busy),
    .done     (done)
  );
endmodule

// File: rtl/capword_serializer_chk.sv
module capword_serializer_chk
  import capword_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic load_req,
  input logic bit_en,
  input logic ser_out,
  input logic busy,
  input logic done
);
  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else if (!busy && load_req) seen_q <= '0;
    else if (busy && bit_en) seen_q <= seen_q + 1'b1;
  end

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!busy && !done && !ser_out));
  a_r2_start_one: assert property (@(posedge clk) disable iff (rst)
    (busy && bit_en && seen_q == '0) |=> ser_out);
  a_r7_load_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && load_req) |=> busy);
  a_r8_stay_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && !(bit_en && seen_q == CNT_W'(FRAME_BITS-1))) |=> busy);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_en) |=> $stable(ser_out));
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r10_done_end: assert property (@(posedge clk) disable iff (rst)
    (busy && bit_en && seen_q == CNT_W'(FRAME_BITS-1)) |=> (done && !busy));
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!busy && bit_en) |=> !ser_out);
endmodule

bind capword_serializer capword_serializer_chk u_chk (.*);

// File: tb/capword_serializer_tb.sv
module capword_serializer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_req = 1'b0;
  logic       ss_type = 1'b0;
  logic [3:0] link_rate = '0;
  logic [2:0] gen_nosup = '0;
  logic [2:0] gen_ssc = '0;
  logic       bit_en = 1'b0;
  logic       ser_out, busy, done;
  int         n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  capword_serializer u_dut (.*);

  function automatic logic [31:0] exp_word(logic s, logic [3:0] r, logic [2:0] n, logic [2:0] c);
    logic [7:0] b0, b1;
    b0 = {1'b1, s, 2'b00, r};
    b1 = {n[0], c[0], n[1], c[1], n[2], c[2], 2'b00};
    return {b0, b1, 8'h00, 7'b0, ^{b0, b1}};
  endfunction

  function automatic string req_of(int k);
    if (k == 0) return "R2";
    if (k == 1 || (k >= 4 && k <= 7)) return "R3";
    if (k >= 8 && k <= 13) return "R4";
    if (k == 31) return "R6";
    return "R5";
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_fields(logic s, logic [3:0] r, logic [2:0] n, logic [2:0] c);
    ss_type = s; link_rate = r; gen_nosup = n; gen_ssc = c;
  endtask

  // noisy: random gaps with load requests; bump: load together with the final strobe
  task automatic send(logic s, logic [3:0] r, logic [2:0] n, logic [2:0] c,
                      bit noisy, bit bump, bit en_at_load, int stop_at);
    logic [31:0] w;
    logic prev;
    w = exp_word(s, r, n, c);
    set_fields(s, r, n, c);
    load_req = 1'b1; bit_en = en_at_load;
    tick();
    load_req = 1'b0; bit_en = 1'b0;
    chk(busy === 1'b1, "R7", busy, 1);
    if (en_at_load) chk(ser_out === 1'b0, "R11", ser_out, 0);
    set_fields(~s, ~r, ~n, ~c); // R7: changes after latch must not matter
    prev = ser_out;
    for (int k = 0; k < 32; k++) begin
      if (k == stop_at) return;
      if (noisy) begin
        int gap = $urandom_range(0, 2);
        for (int g = 0; g < gap; g++) begin
          load_req = $urandom_range(0, 1);
          tick();
          load_req = 1'b0;
          chk(ser_out === prev, "R9", ser_out, prev);
          chk(busy === 1'b1, "R8", busy, 1);
        end
      end
      bit_en = 1'b1;
      if (k == 31 && bump) load_req = 1'b1;
      tick();
      bit_en = 1'b0; load_req = 1'b0;
      chk(ser_out === w[31-k], req_of(k), ser_out, w[31-k]);
      chk(done === (k == 31), "R10", done, k == 31);
      chk(busy === (k != 31), "R10", busy, k != 31);
      prev = ser_out;
    end
    tick();
    chk(done === 1'b0, "R10", done, 0);
    chk(busy === 1'b0, "R8", busy, 0);
    bit_en = 1'b1;
    tick();
    bit_en = 1'b0;
    chk(ser_out === 1'b0, "R11", ser_out, 0);
    chk(busy === 1'b0, "R8", busy, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    tick(); tick();
    rst = 1'b0;
    chk(busy === 1'b0 && done === 1'b0 && ser_out === 1'b0, "R1",
        {busy, done, ser_out}, 0);
    // directed patterns: asymmetric rates, all zero, all one
    send(1'b0, 4'h8, 3'b000, 3'b000, 0, 0, 0, 99);
    send(1'b1, 4'h9, 3'b101, 3'b010, 0, 0, 0, 99);
    send(1'b1, 4'hF, 3'b111, 3'b111, 0, 0, 0, 99);
    send(1'b0, 4'h1, 3'b001, 3'b100, 0, 0, 0, 99);
    // corners: load with idle strobe (R11), load on final strobe (R8)
    send(1'b1, 4'hA, 3'b110, 3'b011, 0, 0, 1, 99);
    send(1'b0, 4'h3, 3'b010, 3'b001, 0, 1, 0, 99);
    // R12: reset mid-frame
    send(1'b1, 4'h5, 3'b011, 3'b101, 0, 0, 0, 10);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk(busy === 1'b0 && done === 1'b0 && ser_out === 1'b0, "R12",
        {busy, done, ser_out}, 0);
    send(1'b1, 4'hC, 3'b100, 3'b110, 0, 0, 0, 99);
    // constrained random frames
    for (int i = 0; i < 30; i++) begin
      send(1'($urandom), 4'($urandom), 3'($urandom), 3'($urandom),
           1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 99);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule